// File: doc/BRIEF.md
# Segmented Predicated Floating-Point Minimum Reduction

This block reduces a wide vector register to one 128-bit result. The vector is cut into 128-bit segments, and element position k of the result is the floating-point minimum of element position k taken from every segment. A per-byte predicate selects which lanes take part. A lane that is switched off counts as positive infinity. The element width is 16, 32 or 64 bits and is picked per operation by a 2-bit size code.

The number of segments is rounded up to a power of two. The slots added by this rounding also hold positive infinity. The minimum is built by a balanced pairwise tree. The operator orders negative zero below positive zero. Any NaN operand yields the default quiet NaN, and a signalling NaN in an active lane raises an invalid flag. An operation is accepted on `valid_i`. Its registered result, flags and a `done_o` pulse appear one clock later.

Top module: `segmin_reduce`

## Requirements
- R1: Size code 01 selects 16-bit elements (8 per result), 10 selects 32-bit (4 per result) and 11 selects 64-bit (2 per result). Result element e occupies result bits [e*w +: w], where w is the element width.
- R2: Size code 00 is reserved. The operation sets `illegal_o`, clears `invalid_o` and gives an all-zero result.
- R3: Result element e is the minimum over segments s = 0..VEC_W/128-1 of vector element s*(128/w)+e. Vector element i sits at vector bits [i*w +: w].
- R4: Vector element i is active when predicate bit i*w/8 (the bit of its lowest byte) is 1. The other predicate bits covering that element have no effect.
- R5: Inactive lanes and power-of-two padding slots act as positive infinity (sign 0, exponent all ones, mantissa 0). With no active lane, every result element is positive infinity at the selected width.
- R6: Ordering follows the sign-magnitude value. Negative zero is smaller than positive zero, and infinities order as the extremes.
- R7: If any active lane of a position is a NaN (exponent all ones, mantissa non-zero), that result element is the default quiet NaN: sign 0, exponent all ones, mantissa MSB 1, other mantissa bits 0. A NaN in an inactive lane has no effect.
- R8: `invalid_o` is 1 exactly when some active lane holds a signalling NaN, meaning a NaN whose mantissa MSB is 0.
- R9: `done_o` is high for exactly the cycle after a cycle with `valid_i` high. Result and flags are registered and hold their values until the next accepted operation.
- R10: While `rst_ni` is low, `done_o`, `illegal_o`, `invalid_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| size_i | input | 2 | Element width code |
| vec_i | input | VEC_W | Source vector |
| pred_i | input | VEC_W/8 | Predicate, one bit per vector byte |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 128 | Reduced result |
| illegal_o | output | 1 | Reserved size code was used |
| invalid_o | output | 1 | Signalling NaN seen in an active lane |

## Verification
The default configuration of three segments always contains one padding slot. A design that padded with zero instead of infinity would therefore return +0 whenever every real lane is positive. The bench sweeps all three widths with lane values drawn from zeros of both signs, infinities, subnormals, quiet and signalling NaNs, and normals, under full, random and sparse predicates.

Directed cases target specific faults. One places the only negative value in a lane whose lowest predicate bit is off while the higher bits are on; a design that read the wrong predicate bit would let that value win. Another mixes +0 and -0; a magnitude-only compare would return +0. Further cases put a NaN or a signalling NaN only in an inactive lane; a design that checked NaNs before masking would corrupt the result or raise a false invalid flag. The reserved code must return zeros with the illegal flag set.

// File: rtl/segmin_pkg.sv
package segmin_pkg;

  typedef enum logic [1:0] {
    SZ_RSVD   = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_SINGLE = 2'b10,
    SZ_DOUBLE = 2'b11
  } size_e;

  localparam int unsigned NUM_WIDTHS = 3;
  localparam int unsigned RES_W      = 128;

  function automatic int unsigned exp_bits(input int unsigned ew);
    if (ew == 16) return 5;
    if (ew == 32) return 8;
    return 11;
  endfunction

  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 32; i++) begin
      if (p < n) p = p * 2;
    end
    return p;
  endfunction

endpackage

// File: rtl/segmin_fmin.sv
module segmin_fmin
  import segmin_pkg::*;
#(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  output logic [EW-1:0] y_o
);
  localparam int unsigned XW = exp_bits(EW);
  localparam int unsigned MW = EW - 1 - XW;
  localparam logic [EW-1:0] QNAN = {1'b0, {XW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic a_nan, b_nan, a_lt;
  logic [EW-2:0] a_mag, b_mag;

  assign a_mag = a_i[EW-2:0];
  assign b_mag = b_i[EW-2:0];
  assign a_nan = (&a_i[EW-2:MW]) & (|a_i[MW-1:0]);
  assign b_nan = (&b_i[EW-2:MW]) & (|b_i[MW-1:0]);

  // sign-magnitude order; -0 < +0 falls out of the sign test
  always_comb begin
    if (a_i[EW-1] != b_i[EW-1]) a_lt = a_i[EW-1];
    else if (a_i[EW-1])         a_lt = a_mag > b_mag;
    else                        a_lt = a_mag < b_mag;
  end

  assign y_o = (a_nan | b_nan) ? QNAN : (a_lt ? a_i : b_i);

endmodule

// File: rtl/segmin_width_unit.sv
module segmin_width_unit
  import segmin_pkg::*;
#(
  parameter int unsigned VEC_W = 384,
  parameter int unsigned EW    = 32
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [VEC_W/8-1:0] pred_i,
  output logic [RES_W-1:0]   res_o,
  output logic               snan_o
);
  localparam int unsigned NPOS  = RES_W / EW;
  localparam int unsigned SEG   = VEC_W / RES_W;
  localparam int unsigned SLOTS = pow2_ceil(SEG);
  localparam int unsigned BPE   = EW / 8;
  localparam int unsigned XW    = exp_bits(EW);
  localparam int unsigned MW    = EW - 1 - XW;
  localparam logic [EW-1:0] P_INF = {1'b0, {XW{1'b1}}, {MW{1'b0}}};

  logic [NPOS-1:0] snan_pos;
  logic            pred_unused;

  // only the lowest-byte bit of each element governs it
  assign pred_unused = ^pred_i;

  for (genvar e = 0; e < NPOS; e++) begin : g_pos
    logic [EW-1:0]  node [1:2*SLOTS-1];
    logic [SEG-1:0] sn;

    for (genvar s = 0; s < SLOTS; s++) begin : g_leaf
      if (s < SEG) begin : g_real
        logic [EW-1:0] lane;
        logic          act;
        assign lane = vec_i[(s*NPOS+e)*EW +: EW];
        assign act  = pred_i[(s*NPOS+e)*BPE];
        assign node[SLOTS+s] = act ? lane : P_INF;
        assign sn[s] = act & (&lane[EW-2:MW]) & (|lane[MW-1:0]) & ~lane[MW-1];
      end else begin : g_pad
        assign node[SLOTS+s] = P_INF;
      end
    end

    // heap layout: node i combines lower half 2i with upper half 2i+1
    for (genvar i = 1; i < SLOTS; i++) begin : g_node
      segmin_fmin #(.EW(EW)) u_min (
        .a_i(node[2*i]),
        .b_i(node[2*i+1]),
        .y_o(node[i])
      );
    end

    assign res_o[e*EW +: EW] = node[1];
    assign snan_pos[e]       = |sn;
  end

  assign snan_o = |snan_pos;

endmodule

// File: rtl/segmin_reduce.sv
module segmin_reduce
  import segmin_pkg::*;
#(
  parameter int unsigned VEC_W = 384
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         size_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [VEC_W/8-1:0] pred_i,
  output logic               done_o,
  output logic [RES_W-1:0]   result_o,
  output logic               illegal_o,
  output logic               invalid_o
);
  logic [RES_W-1:0]      res_w [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] snan_w;
  logic [RES_W-1:0]      nxt_res;
  logic                  nxt_inv, nxt_ill;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    segmin_width_unit #(.VEC_W(VEC_W), .EW(16 << g)) u_unit (
      .vec_i (vec_i),
      .pred_i(pred_i),
      .res_o (res_w[g]),
      .snan_o(snan_w[g])
    );
  end

  always_comb begin
    nxt_res = '0;
    nxt_inv = 1'b0;
    nxt_ill = 1'b0;
    case (size_i)
      SZ_HALF:   begin nxt_res = res_w[0]; nxt_inv = snan_w[0]; end
      SZ_SINGLE: begin nxt_res = res_w[1]; nxt_inv = snan_w[1]; end
      SZ_DOUBLE: begin nxt_res = res_w[2]; nxt_inv = snan_w[2]; end
      default:   nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt_res;
        illegal_o <= nxt_ill;
        invalid_o <= nxt_inv;
      end
    end
  end

endmodule

// File: rtl/segmin_reduce_chk.sv
module segmin_reduce_chk #(
  parameter int unsigned VEC_W = 384
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         size_i,
  input logic [VEC_W/8-1:0] pred_i,
  input logic               done_o,
  input logic [127:0]       result_o,
  input logic               illegal_o,
  input logic               invalid_o
);
  function automatic logic [127:0] inf_pat(input logic [1:0] sz);
    case (sz)
      2'b01:   return {8{16'h7C00}};
      2'b10:   return {4{32'h7F80_0000}};
      2'b11:   return {2{64'h7FF0_0000_0000_0000}};
      default: return '0;
    endcase
  endfunction

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  p_no_stray_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o) && $stable(invalid_o)));

  p_rsvd_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b00) |=> (illegal_o && !invalid_o && result_o == '0));

  p_legal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != 2'b00) |=> !illegal_o);

  p_all_off_inf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != 2'b00 && pred_i == '0) |=>
      (result_o == inf_pat($past(size_i)) && !invalid_o));

  always_comb begin
    if (!rst_ni) begin
      p_reset_clear_r10: assert (!done_o && !illegal_o && !invalid_o && result_o == '0);
    end
  end

endmodule

bind segmin_reduce segmin_reduce_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_segmin_reduce.sv
module tb_segmin_reduce;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W  = 384;
  localparam int PRED_W = VEC_W / 8;
  localparam int SEG    = VEC_W / 128;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [1:0]         size_i = '0;
  logic [VEC_W-1:0]   vec_i = '0;
  logic [PRED_W-1:0]  pred_i = '0;
  logic               done_o;
  logic [127:0]       result_o;
  logic               illegal_o;
  logic               invalid_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  segmin_reduce #(.VEC_W(VEC_W)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ebits(input int w);
    return (w == 16) ? 5 : (w == 32) ? 8 : 11;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
  endfunction

  function automatic logic [63:0] okey(input logic [63:0] x, input int w);
    if (x[w-1]) return ~x & wmask(w);
    return x | (64'd1 << (w - 1));
  endfunction

  task automatic ref_calc(input logic [1:0] sz, input logic [VEC_W-1:0] v, input logic [PRED_W-1:0] p,
                          output logic [127:0] r, output logic ill, output logic inv);
    int w, mw, npos;
    logic [63:0] msk, expm, manm, qn, acc, x;
    bit nan;
    r = '0; ill = 0; inv = 0;
    if (sz == 2'b00) begin ill = 1; return; end
    w = 8 << sz;
    mw = w - 1 - ebits(w);
    npos = 128 / w;
    msk = wmask(w);
    manm = (64'd1 << mw) - 1;
    expm = msk & ~manm & ~(64'd1 << (w - 1));
    qn = expm | (64'd1 << (mw - 1));
    for (int e = 0; e < npos; e++) begin
      acc = expm;
      nan = 0;
      for (int s = 0; s < SEG; s++) begin
        int idx;
        idx = s * npos + e;
        if (p[idx * w / 8]) begin
          x = 64'(v >> (idx * w)) & msk;
          if ((x & expm) == expm && (x & manm) != 0) begin
            nan = 1;
            if (x[mw-1] == 1'b0) inv = 1;
          end else if (okey(x, w) < okey(acc, w)) acc = x;
        end
      end
      r = r | (128'(nan ? qn : acc) << (e * w));
    end
  endtask

  function automatic logic [VEC_W-1:0] put(input logic [VEC_W-1:0] v, input int idx, input int w, input logic [63:0] val);
    logic [VEC_W-1:0] m;
    m = VEC_W'(wmask(w)) << (idx * w);
    return (v & ~m) | (VEC_W'(val & wmask(w)) << (idx * w));
  endfunction

  function automatic logic [VEC_W-1:0] fill(input int w, input logic [63:0] val);
    logic [VEC_W-1:0] v = '0;
    for (int i = 0; i < VEC_W / w; i++) v = put(v, i, w, val);
    return v;
  endfunction

  function automatic logic [63:0] pick(input int w);
    int ew, mw, cat;
    logic [63:0] sgn, expo, man, rnd;
    ew = ebits(w);
    mw = w - 1 - ew;
    cat = $urandom % 10;
    sgn = 64'($urandom % 2) << (w - 1);
    rnd = {$urandom, $urandom};
    man = rnd & ((64'd1 << mw) - 1);
    case (cat)
      0: return sgn;
      1: return sgn | (((64'd1 << ew) - 1) << mw);
      2: return sgn | (((64'd1 << ew) - 1) << mw) | (64'd1 << (mw - 1)) | (man >> 1);
      3: return sgn | (((64'd1 << ew) - 1) << mw) | ((man >> 1) | 64'd1);
      4: return sgn | (man | 64'd1);
      default: begin
        expo = 64'(1 + ($urandom % (2 ** ew - 2)));
        return sgn | (expo << mw) | man;
      end
    endcase
  endfunction

  logic [127:0] last_res;

  task automatic do_op(input logic [1:0] sz, input logic [VEC_W-1:0] v, input logic [PRED_W-1:0] p, input string req);
    logic [127:0] er;
    logic eill, einv;
    ref_calc(sz, v, p, er, eill, einv);
    @(negedge clk_i);
    valid_i = 1'b1; size_i = sz; vec_i = v; pred_i = p;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(done_o === 1'b1, {req, " done (R9)"}, 128'(done_o), 128'd1);
    chk(result_o === er, {req, " result"}, result_o, er);
    chk(illegal_o === eill && invalid_o === einv, {req, " flags (R8)"},
        128'({illegal_o, invalid_o}), 128'({eill, einv}));
    last_res = er;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] v;
    logic [PRED_W-1:0] p;
    logic [127:0] exp_r;

    #(CLK_PERIOD * 2 + 1);
    chk(!done_o && !illegal_o && !invalid_o && result_o == '0, "R10 reset", result_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 placement: segment 0 element e = 1.0+e ulp, other segments +inf
    v = fill(16, 64'h7C00);
    exp_r = '0;
    for (int e = 0; e < 8; e++) begin
      v = put(v, e, 16, 64'h3C00 + 64'(e));
      exp_r[e*16 +: 16] = 16'h3C00 + 16'(e);
    end
    do_op(2'b01, v, '1, "R1");
    chk(result_o == exp_r, "R1 element placement", result_o, exp_r);

    // R2 reserved code
    do_op(2'b00, fill(32, 64'hBF80_0000), '1, "R2");
    chk(illegal_o && result_o == '0, "R2 reserved", result_o, '0);

    // R3 minimum found in the last segment
    v = fill(64, 64'h4000_0000_0000_0000);
    v = put(v, 2 * 2 + 1, 64, 64'hC000_0000_0000_0000);
    do_op(2'b11, v, '1, "R3");
    exp_r = {64'hC000_0000_0000_0000, 64'h4000_0000_0000_0000};
    chk(result_o == exp_r, "R3 last segment min", result_o, exp_r);

    // R4 lowest predicate bit off, higher bits on: -1 must be ignored
    v = fill(32, 64'h4000_0000);
    v = put(v, 5, 32, 64'hBF80_0000);
    p = '1;
    p[20] = 1'b0;
    do_op(2'b10, v, p, "R4");
    chk(result_o[63:32] == 32'h4000_0000, "R4 masked lane", 128'(result_o[63:32]), 128'h4000_0000);

    // R5 nothing active, and padding with positive finite lanes
    do_op(2'b11, fill(64, 64'hFFF0_0000_0000_0001), '0, "R5");
    exp_r = {2{64'h7FF0_0000_0000_0000}};
    chk(result_o == exp_r && !invalid_o, "R5 all inactive", result_o, exp_r);
    do_op(2'b01, fill(16, 64'h7BFF), '1, "R5");
    chk(result_o == {8{16'h7BFF}}, "R5 padding not zero", result_o, {8{16'h7BFF}});

    // R6 signed zeros
    v = fill(16, 64'h3C00);
    v = put(v, 0, 16, 64'h0000);
    v = put(v, 8, 16, 64'h8000);
    v = put(v, 16, 16, 64'h0000);
    do_op(2'b01, v, '1, "R6");
    chk(result_o[15:0] == 16'h8000, "R6 -0 below +0", 128'(result_o[15:0]), 128'h8000);

    // R7 active qNaN and inactive NaN
    v = fill(32, 64'h3F80_0000);
    v = put(v, 2 * 4 + 1, 32, 64'h7FC0_0001);
    v = put(v, 1 * 4 + 2, 32, 64'h7FC1_2345);
    p = '1;
    p[24] = 1'b0;
    do_op(2'b10, v, p, "R7");
    exp_r = {32'h3F80_0000, 32'h3F80_0000, 32'h7FC0_0000, 32'h3F80_0000};
    chk(result_o == exp_r, "R7 nan handling", result_o, exp_r);

    // R8 sNaN active and inactive
    v = fill(64, 64'h3FF0_0000_0000_0000);
    v = put(v, 0, 64, 64'h7FF0_0000_0000_0001);
    do_op(2'b11, v, '1, "R8");
    chk(invalid_o && result_o[63:0] == 64'h7FF8_0000_0000_0000, "R8 active snan",
        result_o, 128'h7FF8_0000_0000_0000);
    p = '1;
    p[0] = 1'b0;
    do_op(2'b11, v, p, "R8");
    chk(!invalid_o, "R8 inactive snan", 128'(invalid_o), '0);

    // R9 idle cycles with changing inputs hold the result
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      size_i = 2'(k); vec_i = ~vec_i; pred_i = ~pred_i;
      @(negedge clk_i);
      chk(!done_o && result_o == last_res, "R9 hold", result_o, last_res);
    end

    // R3 sweep over all widths and predicate styles
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 0; n < 1200; n++) begin
        int w;
        w = (sz == 0) ? 16 : (8 << sz);
        v = '0;
        for (int i = 0; i < VEC_W / w; i++) v = put(v, i, w, pick(w));
        p = PRED_W'({$urandom, $urandom});
        case (n % 4)
          0: p = '1;
          3: p = p & PRED_W'({$urandom, $urandom});
          default: ;
        endcase
        do_op(2'(sz), v, p, "R3 sweep");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule